// File: doc/BRIEF.md
# Dual-Protocol Multiplexed Bus Target

This block is the target side of an 8-bit bus on which address and data share the same wires. One static mode input decides how the strobe pins are read. With the mode high, the pins follow the Motorola convention: an address strobe, a data strobe and a read/write level. With the mode low, the same pins follow the Intel convention: an address latch enable, an active-low read and an active-low write. A strobe falling edge captures a 7-bit address. Reads and writes then reach a 128-location register and RAM space through a simple internal port.

Every bus pin passes through a synchronizer into the system clock domain, and all edges are detected on the synchronized samples. The block drives the data pins only while a valid read phase lasts, and it reports this on an output-enable signal. A chip select gates every access. An internal inhibit input (power fail or reset) forces that gate closed. Three locations are guarded: two are fully read-only, and the top bit of a third is read-only. The storage behind the internal port is not part of this block.

Top module: `mbus_target`

## Requirements
- R1: With `mode_mot` = 1 the strobe pins are decoded as data strobe (`ds_rd`, active high) and read/write level (`rw_wr`, 1 = read). With `mode_mot` = 0 they are decoded as active-low read (`ds_rd`) and active-low write (`rw_wr`).
- R2: A falling edge on `as_ale` captures `ad_in[6:0]` as the address and shows it on `mem_addr`. `ad_in[7]` is not part of the address.
- R3: A rising edge on `as_ale` clears the captured address to 0 and marks it invalid, whatever the chip select level. No access takes place until a new falling edge arrives.
- R4: In Motorola mode, with chip select active, `ds_rd` high and `rw_wr` high, `ad_oe` goes to 1 and `ad_out` carries the stored byte at the address. `ad_oe` returns to 0 when `ds_rd` falls.
- R5: In Motorola mode, a falling edge of `ds_rd` while `rw_wr` is low performs one write of the `ad_in` value present at that edge, as a single-cycle `mem_we` pulse.
- R6: In Intel mode, `ds_rd` low drives the stored byte with `ad_oe` = 1. `ad_oe` returns to 0 when `ds_rd` rises.
- R7: In Intel mode, the rising edge of `rw_wr` performs one write of the `ad_in` value present at that edge.
- R8: With `cs_n` high, no read drives the bus and no write reaches storage, but the address is still captured on `mem_addr`.
- R9: While `inhibit` is 1, no write reaches storage and `ad_oe` is 0 from the next clock on, even during an ongoing read.
- R10: Writes to address 12 and address 13 are discarded. A write to address 10 stores the new bits 6..0 and keeps the stored bit 7.
- R11: After reset, `ad_oe` = 0, `mem_we` = 0, `mem_rd` = 0 and `mem_addr` = 0.
- R12: Each read phase raises `mem_rd` for exactly one cycle, and `ad_out` holds the byte sampled at the start of the phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_mot | input | 1 | Protocol select: 1 Motorola, 0 Intel |
| inhibit | input | 1 | Forces chip select inactive |
| cs_n | input | 1 | Active-low chip select |
| as_ale | input | 1 | Address strobe / address latch enable |
| ds_rd | input | 1 | Data strobe (Motorola) or read, active low (Intel) |
| rw_wr | input | 1 | Read/write level (Motorola) or write, active low (Intel) |
| ad_in | input | 8 | Multiplexed address/data pins, input side |
| ad_out | output | 8 | Read data driven onto the pins |
| ad_oe | output | 1 | Pin driver enable for `ad_out` |
| mem_addr | output | 7 | Storage address |
| mem_rd | output | 1 | One-cycle read-start strobe for storage |
| mem_we | output | 1 | One-cycle storage write enable |
| mem_wdata | output | 8 | Storage write data |
| mem_rdata | input | 8 | Storage read data for `mem_addr` |

## Verification
The bench uses the default parameters: 8-bit data, 7-bit address, two synchronizer stages, and guarded locations at 10, 12 and 13. With a 7-bit address, an address byte whose top bit is set shows that bit 7 is dropped. With two synchronizer stages, a response arrives three clocks after a pin change, so every check can sample at a fixed point. Because the guarded addresses sit inside the 128 locations the bench models, discarded writes and the kept bit can be read back over the bus in both protocols.

// File: rtl/mbus_pkg.sv
package mbus_pkg;

    typedef enum logic {
        BUS_INTEL    = 1'b0,
        BUS_MOTOROLA = 1'b1
    } bus_mode_e;

    // control pins as one bundle, synchronized together
    typedef struct packed {
        logic cs_n;
        logic as_ale;
        logic ds_rd;
        logic rw_wr;
    } bus_pins_t;

    localparam int PIN_COUNT = $bits(bus_pins_t);

endpackage

// File: rtl/mbus_sync.sv
module mbus_sync #(
    parameter int W      = 4,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    localparam int LAST = STAGES - 1;

    typedef struct packed {
        logic [STAGES-1:0][W-1:0] chain;
    } sync_st_t;

    sync_st_t st_d, st_q;

    always_comb begin
        st_d          = st_q;
        st_d.chain[0] = din;
        for (int i = 1; i < STAGES; i++) begin
            st_d.chain[i] = st_q.chain[i-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign dout = st_q.chain[LAST];

endmodule

// File: rtl/mbus_addr_latch.sv
module mbus_addr_latch #(
    parameter int ADDR_W = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              as_s,
    input  logic [ADDR_W-1:0] bus_s,
    output logic [ADDR_W-1:0] addr,
    output logic              addr_valid
);
    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic              valid;
        logic              as_prev;
    } latch_st_t;

    latch_st_t st_d, st_q;
    logic      as_rise, as_fall;

    always_comb begin
        as_rise      = as_s && !st_q.as_prev;
        as_fall      = !as_s && st_q.as_prev;
        st_d         = st_q;
        st_d.as_prev = as_s;
        if (as_fall) begin
            st_d.addr  = bus_s;
            st_d.valid = 1'b1;
        end else if (as_rise) begin
            st_d.addr  = '0;
            st_d.valid = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign addr       = st_q.addr;
    assign addr_valid = st_q.valid;

    AST_STROBE_FALL_ARMS: assert property (@(posedge clk) disable iff (!rst_n)
        as_fall |=> addr_valid); // R2

    AST_STROBE_RISE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        as_rise |=> (!addr_valid && addr == '0)); // R3

endmodule

// File: rtl/mbus_wr_guard.sv
module mbus_wr_guard #(
    parameter int ADDR_W    = 7,
    parameter int DATA_W    = 8,
    parameter int KEEP_ADDR = 10,
    parameter int KEEP_BIT  = 7,
    parameter int LOCK_A    = 12,
    parameter int LOCK_B    = 13
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [DATA_W-1:0] cur,
    output logic              allow,
    output logic [DATA_W-1:0] wdata_out
);
    localparam logic [ADDR_W-1:0] KEEP_A = ADDR_W'(KEEP_ADDR);
    localparam logic [ADDR_W-1:0] LOCK_0 = ADDR_W'(LOCK_A);
    localparam logic [ADDR_W-1:0] LOCK_1 = ADDR_W'(LOCK_B);

    logic keep_hit;

    assign keep_hit = (addr == KEEP_A);
    assign allow    = (addr != LOCK_0) && (addr != LOCK_1);

    // per-bit merge: protected bit keeps the stored value
    for (genvar b = 0; b < DATA_W; b++) begin : g_merge
        if (b == KEEP_BIT) begin : g_keep
            assign wdata_out[b] = keep_hit ? cur[b] : wdata[b];
        end else begin : g_pass
            assign wdata_out[b] = wdata[b];
        end
    end

endmodule

// File: rtl/mbus_access_ctrl.sv
module mbus_access_ctrl
    import mbus_pkg::*;
#(
    parameter int ADDR_W    = 7,
    parameter int DATA_W    = 8,
    parameter int KEEP_ADDR = 10,
    parameter int KEEP_BIT  = 7,
    parameter int LOCK_A    = 12,
    parameter int LOCK_B    = 13
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mode_mot,
    input  logic              inhibit,
    input  logic              cs_n_s,
    input  logic              ds_s,
    input  logic              rw_s,
    input  logic [DATA_W-1:0] bus_s,
    input  logic [ADDR_W-1:0] addr,
    input  logic              addr_valid,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic [DATA_W-1:0] ad_out,
    output logic              ad_oe,
    output logic              mem_rd,
    output logic              mem_we,
    output logic [DATA_W-1:0] mem_wdata
);
    localparam logic [ADDR_W-1:0] KEEP_A = ADDR_W'(KEEP_ADDR);
    localparam logic [ADDR_W-1:0] LOCK_0 = ADDR_W'(LOCK_A);
    localparam logic [ADDR_W-1:0] LOCK_1 = ADDR_W'(LOCK_B);

    typedef struct packed {
        logic              ds_prev;
        logic              rw_prev;
        logic              oe;
        logic              rd_pulse;
        logic              we;
        logic [DATA_W-1:0] dout;
        logic [DATA_W-1:0] wdata;
    } ctrl_st_t;

    ctrl_st_t          st_d, st_q;
    bus_mode_e         mode;
    logic              ce, rd_win, rd_start, wr_evt;
    logic              ds_fall, rw_rise, wr_ok;
    logic [DATA_W-1:0] wr_data_g;

    mbus_wr_guard #(
        .ADDR_W   (ADDR_W),
        .DATA_W   (DATA_W),
        .KEEP_ADDR(KEEP_ADDR),
        .KEEP_BIT (KEEP_BIT),
        .LOCK_A   (LOCK_A),
        .LOCK_B   (LOCK_B)
    ) u_guard (
        .addr     (addr),
        .wdata    (bus_s),
        .cur      (mem_rdata),
        .allow    (wr_ok),
        .wdata_out(wr_data_g)
    );

    always_comb begin
        mode    = bus_mode_e'(mode_mot);
        ce      = !cs_n_s && !inhibit;
        ds_fall = st_q.ds_prev && !ds_s;
        rw_rise = !st_q.rw_prev && rw_s;

        if (mode == BUS_MOTOROLA) begin
            rd_win = ce && addr_valid && ds_s && rw_s;
            wr_evt = ce && addr_valid && ds_fall && !rw_s;
        end else begin
            rd_win = ce && addr_valid && !ds_s;
            wr_evt = ce && addr_valid && rw_rise;
        end
        rd_start = rd_win && !st_q.oe;

        st_d          = st_q;
        st_d.ds_prev  = ds_s;
        st_d.rw_prev  = rw_s;
        st_d.oe       = rd_win;
        st_d.rd_pulse = rd_start;
        if (rd_start) begin
            st_d.dout = mem_rdata;
        end
        st_d.we = wr_evt && wr_ok;
        if (wr_evt) begin
            st_d.wdata = wr_data_g;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign ad_out    = st_q.dout;
    assign ad_oe     = st_q.oe;
    assign mem_rd    = st_q.rd_pulse;
    assign mem_we    = st_q.we;
    assign mem_wdata = st_q.wdata;

    AST_WRITE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |=> !mem_we); // R5

    AST_READ_STROBE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd |=> !mem_rd); // R12

    AST_LOCKED_NEVER_WRITTEN: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> (addr != LOCK_0 && addr != LOCK_1)); // R10

    AST_KEEP_BIT_PRESERVED: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we && addr == KEEP_A) |-> (mem_wdata[KEEP_BIT] == mem_rdata[KEEP_BIT])); // R10

    AST_INHIBIT_SILENCES: assert property (@(posedge clk) disable iff (!rst_n)
        $past(inhibit) |-> (!ad_oe && !mem_we)); // R9

    AST_DATA_HELD_IN_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (ad_oe && $past(ad_oe)) |-> $stable(ad_out)); // R12

endmodule

// File: rtl/mbus_target.sv
module mbus_target
    import mbus_pkg::*;
#(
    parameter int ADDR_W      = 7,
    parameter int DATA_W      = 8,
    parameter int SYNC_STAGES = 2,
    parameter int KEEP_ADDR   = 10,
    parameter int KEEP_BIT    = 7,
    parameter int LOCK_A      = 12,
    parameter int LOCK_B      = 13
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mode_mot,
    input  logic              inhibit,
    input  logic              cs_n,
    input  logic              as_ale,
    input  logic              ds_rd,
    input  logic              rw_wr,
    input  logic [DATA_W-1:0] ad_in,
    output logic [DATA_W-1:0] ad_out,
    output logic              ad_oe,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_rd,
    output logic              mem_we,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic [DATA_W-1:0] mem_rdata
);
    bus_pins_t         pins_raw, pins_s;
    logic [DATA_W-1:0] bus_s;
    logic [ADDR_W-1:0] addr;
    logic              addr_valid;

    assign pins_raw = '{cs_n: cs_n, as_ale: as_ale, ds_rd: ds_rd, rw_wr: rw_wr};

    mbus_sync #(.W(PIN_COUNT), .STAGES(SYNC_STAGES)) u_sync_ctrl (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (pins_raw),
        .dout (pins_s)
    );

    mbus_sync #(.W(DATA_W), .STAGES(SYNC_STAGES)) u_sync_bus (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (ad_in),
        .dout (bus_s)
    );

    mbus_addr_latch #(.ADDR_W(ADDR_W)) u_addr (
        .clk       (clk),
        .rst_n     (rst_n),
        .as_s      (pins_s.as_ale),
        .bus_s     (bus_s[ADDR_W-1:0]),
        .addr      (addr),
        .addr_valid(addr_valid)
    );

    mbus_access_ctrl #(
        .ADDR_W   (ADDR_W),
        .DATA_W   (DATA_W),
        .KEEP_ADDR(KEEP_ADDR),
        .KEEP_BIT (KEEP_BIT),
        .LOCK_A   (LOCK_A),
        .LOCK_B   (LOCK_B)
    ) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .mode_mot  (mode_mot),
        .inhibit   (inhibit),
        .cs_n_s    (pins_s.cs_n),
        .ds_s      (pins_s.ds_rd),
        .rw_s      (pins_s.rw_wr),
        .bus_s     (bus_s),
        .addr      (addr),
        .addr_valid(addr_valid),
        .mem_rdata (mem_rdata),
        .ad_out    (ad_out),
        .ad_oe     (ad_oe),
        .mem_rd    (mem_rd),
        .mem_we    (mem_we),
        .mem_wdata (mem_wdata)
    );

    assign mem_addr = addr;

    AST_NO_DRIVE_WITHOUT_SELECT: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(inhibit) || $past(pins_s.cs_n)) |-> !ad_oe); // R8

    AST_NO_WRITE_WITHOUT_SELECT: assert property (@(posedge clk) disable iff (!rst_n)
        $past(pins_s.cs_n) |-> !mem_we); // R8

endmodule

// File: tb/mbus_target_tb.sv
`timescale 1ns/1ps
module mbus_target_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       mode_mot = 1'b1;
    logic       inhibit = 1'b0;
    logic       cs_n = 1'b1;
    logic       as_ale = 1'b0;
    logic       ds_rd = 1'b0;
    logic       rw_wr = 1'b1;
    logic [7:0] ad_in = 8'h00;
    logic [7:0] ad_out;
    logic       ad_oe;
    logic [6:0] mem_addr;
    logic       mem_rd;
    logic       mem_we;
    logic [7:0] mem_wdata;
    logic [7:0] mem_rdata;

    logic [7:0] mem [128];
    logic [7:0] expv [128];
    int         n_checks = 0;
    int         n_fail = 0;
    int         we_cnt = 0;
    int         rd_cnt = 0;

    always #2.5 clk = ~clk;

    mbus_target u_dut (
        .clk      (clk),
        .rst_n    (rst_n),
        .mode_mot (mode_mot),
        .inhibit  (inhibit),
        .cs_n     (cs_n),
        .as_ale   (as_ale),
        .ds_rd    (ds_rd),
        .rw_wr    (rw_wr),
        .ad_in    (ad_in),
        .ad_out   (ad_out),
        .ad_oe    (ad_oe),
        .mem_addr (mem_addr),
        .mem_rd   (mem_rd),
        .mem_we   (mem_we),
        .mem_wdata(mem_wdata),
        .mem_rdata(mem_rdata)
    );

    // storage stand-in behind the internal port
    assign mem_rdata = mem[mem_addr];

    always @(posedge clk) begin
        if (mem_we) begin
            mem[mem_addr] <= mem_wdata;
            we_cnt++;
        end
        if (mem_rd) rd_cnt++;
    end

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input logic ok, input string req, input int act, input int exp_v);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp_v);
        end
    endtask

    task automatic set_idle(input logic mot);
        mode_mot = mot;
        cs_n     = 1'b1;
        as_ale   = 1'b0;
        ds_rd    = mot ? 1'b0 : 1'b1;
        rw_wr    = 1'b1;
        tick(4);
    endtask

    task automatic put_addr(input logic [7:0] a);
        ad_in  = a;
        as_ale = 1'b1;
        tick(4);
        as_ale = 1'b0;
        tick(4);
    endtask

    task automatic mot_write(input logic [7:0] a, input logic [7:0] d, input logic sel);
        cs_n = !sel;
        put_addr(a);
        ad_in = d;
        rw_wr = 1'b0;
        tick(1);
        ds_rd = 1'b1;
        tick(4);
        ds_rd = 1'b0;
        tick(6);
        rw_wr = 1'b1;
        cs_n  = 1'b1;
        tick(2);
    endtask

    task automatic mot_read(input logic [7:0] a, input logic [7:0] e, input string req);
        cs_n = 1'b0;
        put_addr(a);
        rw_wr = 1'b1;
        ds_rd = 1'b1;
        tick(5);
        chk(ad_oe === 1'b1, req, ad_oe, 1);
        chk(ad_out === e, req, ad_out, e);
        ds_rd = 1'b0;
        tick(5);
        chk(ad_oe === 1'b0, req, ad_oe, 0);
        cs_n = 1'b1;
        tick(2);
    endtask

    task automatic int_write(input logic [7:0] a, input logic [7:0] d);
        cs_n = 1'b0;
        put_addr(a);
        ad_in = d;
        rw_wr = 1'b0;
        tick(4);
        rw_wr = 1'b1;
        tick(6);
        cs_n = 1'b1;
        tick(2);
    endtask

    task automatic int_read(input logic [7:0] a, input logic [7:0] e, input string req);
        cs_n = 1'b0;
        put_addr(a);
        ds_rd = 1'b0;
        tick(5);
        chk(ad_oe === 1'b1, req, ad_oe, 1);
        chk(ad_out === e, req, ad_out, e);
        ds_rd = 1'b1;
        tick(5);
        chk(ad_oe === 1'b0, req, ad_oe, 0);
        cs_n = 1'b1;
        tick(2);
    endtask

    task automatic t_reset();
        chk(ad_oe === 1'b0, "R11 oe", ad_oe, 0);
        chk(mem_we === 1'b0, "R11 we", mem_we, 0);
        chk(mem_rd === 1'b0, "R11 rd", mem_rd, 0);
        chk(mem_addr === 7'd0, "R11 addr", mem_addr, 0);
    endtask

    task automatic t_motorola();
        int w0, r0;
        set_idle(1'b1);
        w0 = we_cnt;
        mot_write(8'h20, 8'hA5, 1'b1);
        expv[8'h20] = 8'hA5;
        chk(we_cnt == w0 + 1, "R5 single write", we_cnt - w0, 1);
        r0 = rd_cnt;
        mot_read(8'h20, expv[8'h20], "R4 R1 motorola read");
        chk(rd_cnt == r0 + 1, "R12 one read strobe", rd_cnt - r0, 1);
        mot_read(8'h05, expv[8'h05], "R4 untouched location");
    endtask

    task automatic t_intel();
        int w0;
        set_idle(1'b0);
        w0 = we_cnt;
        int_write(8'h33, 8'h3C);
        expv[8'h33] = 8'h3C;
        chk(we_cnt == w0 + 1, "R7 single write", we_cnt - w0, 1);
        int_read(8'h33, expv[8'h33], "R6 R1 intel read");
        int_read(8'h7F, expv[8'h7F], "R6 top location");
    endtask

    task automatic t_addr_bit7();
        set_idle(1'b1);
        cs_n = 1'b0;
        put_addr(8'hA1);
        chk(mem_addr === 7'h21, "R2 address bits", mem_addr, 8'h21);
        cs_n = 1'b1;
        tick(2);
        mot_write(8'hA1, 8'h6E, 1'b1);
        expv[8'h21] = 8'h6E;
        mot_read(8'h21, expv[8'h21], "R2 write landed at low address");
    endtask

    task automatic t_strobe_clear();
        set_idle(1'b1);
        cs_n = 1'b1;
        put_addr(8'h30);
        chk(mem_addr === 7'h30, "R8 address latched without select", mem_addr, 8'h30);
        as_ale = 1'b1;
        tick(4);
        chk(mem_addr === 7'h00, "R3 rise clears address", mem_addr, 0);
        cs_n  = 1'b0;
        rw_wr = 1'b1;
        ds_rd = 1'b1;
        tick(5);
        chk(ad_oe === 1'b0, "R3 no access after clear", ad_oe, 0);
        ds_rd = 1'b0;
        tick(2);
        cs_n = 1'b1;
        tick(2);
        as_ale = 1'b0;
        tick(4);
    endtask

    task automatic t_no_select();
        int w0;
        set_idle(1'b1);
        w0 = we_cnt;
        mot_write(8'h40, 8'h5A, 1'b0);
        chk(we_cnt == w0, "R8 no write without select", we_cnt - w0, 0);
        put_addr(8'h40);
        rw_wr = 1'b1;
        ds_rd = 1'b1;
        tick(5);
        chk(ad_oe === 1'b0, "R8 no drive without select", ad_oe, 0);
        ds_rd = 1'b0;
        tick(3);
        mot_read(8'h40, expv[8'h40], "R8 location unchanged");
    endtask

    task automatic t_inhibit();
        int w0;
        set_idle(1'b1);
        cs_n = 1'b0;
        put_addr(8'h21);
        rw_wr = 1'b1;
        ds_rd = 1'b1;
        tick(5);
        chk(ad_oe === 1'b1, "R9 read before inhibit", ad_oe, 1);
        inhibit = 1'b1;
        tick(2);
        chk(ad_oe === 1'b0, "R9 inhibit releases bus", ad_oe, 0);
        ds_rd = 1'b0;
        tick(3);
        cs_n = 1'b1;
        tick(2);
        w0 = we_cnt;
        mot_write(8'h22, 8'hEE, 1'b1);
        chk(we_cnt == w0, "R9 inhibit blocks write", we_cnt - w0, 0);
        inhibit = 1'b0;
        tick(3);
        mot_read(8'h22, expv[8'h22], "R9 location unchanged");
    endtask

    task automatic t_read_only();
        set_idle(1'b1);
        mot_write(8'h0C, 8'h11, 1'b1);
        mot_write(8'h0D, 8'h22, 1'b1);
        mot_read(8'h0C, expv[8'h0C], "R10 addr 12 unchanged");
        mot_read(8'h0D, expv[8'h0D], "R10 addr 13 unchanged");
        mot_write(8'h0A, 8'h15, 1'b1);
        expv[8'h0A] = {expv[8'h0A][7], 7'h15};
        mot_read(8'h0A, expv[8'h0A], "R10 addr 10 keeps bit 7 set");
        set_idle(1'b0);
        int_write(8'h0A, 8'h80);
        expv[8'h0A] = {expv[8'h0A][7], 7'h00};
        int_read(8'h0A, expv[8'h0A], "R10 addr 10 intel write");
        int_write(8'h0C, 8'h99);
        int_read(8'h0C, expv[8'h0C], "R10 intel addr 12 unchanged");
    endtask

    initial begin
        for (int i = 0; i < 128; i++) begin
            mem[i]  = 8'(i * 7 + 3);
            expv[i] = 8'(i * 7 + 3);
        end
        mem[10]  = 8'hC3;
        expv[10] = 8'hC3;
        tick(1);
        #1;
        t_reset();
        tick(3);
        rst_n = 1'b1;
        tick(3);
        t_reset();
        t_motorola();
        t_intel();
        t_addr_bit7();
        t_strobe_clear();
        t_no_select();
        t_inhibit();
        t_read_only();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule